// File: doc/BRIEF.md
# Segment Base-Limit Address Translator

This block turns a two-part logical address, made of a segment number and an offset inside that segment, into a flat physical address. It looks up a descriptor for the segment in an on-block table. Each descriptor holds a physical start address and a segment length. Before any lookup result is used, two bound checks run in a fixed order. First, the segment number is compared with a programmable table length. Second, the offset is compared with the length stored in the selected descriptor. Only a request that passes both checks receives a physical address, which is the start address plus the offset.

The descriptor storage is split into several banks. A control register picks the bank that lookups use and holds the table length. Software-side logic fills the descriptors one entry per cycle through a write port, and it programs the control register through a separate write strobe. Each request is answered one clock later with a registered result. That result is either a valid physical address or a trap carrying a two-bit cause code.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset the outputs are all zero, the selected bank is 0 and the table length is 0, so any request traps with cause 01.
- R2: A result appears on the outputs exactly one clock after the request cycle. A cycle with `rq_valid_i` low yields `rs_valid_o`=0, `rs_trap_o`=00 and `rs_paddr_o`=0 one cycle later.
- R3: A request whose segment number is greater than or equal to the table length produces `rs_trap_o`=01, `rs_valid_o`=0 and `rs_paddr_o`=0.
- R4: A request with the segment in range and an offset greater than or equal to the descriptor's length produces `rs_trap_o`=10, `rs_valid_o`=0 and `rs_paddr_o`=0. An offset of length-1 passes, and a length of 0 traps every offset.
- R5: A request that passes both checks produces `rs_valid_o`=1, `rs_trap_o`=00 and `rs_paddr_o` equal to the start address plus the zero-extended offset, taken modulo 2^PA_W.
- R6: When both checks fail, the segment-range cause 01 is reported. The trap output never carries 11.
- R7: A table write stores the start address and length of the single entry addressed by bank and segment. A lookup of that entry in the same cycle returns the old contents, and a lookup in the next cycle returns the new contents.
- R8: Lookups use only the bank named by the control register. Writes to another bank leave the results of the selected bank unchanged.
- R9: A control register write takes effect for requests from the following cycle onward. A request in the write cycle uses the old bank and length.
- R10: A table length of 2^SEG_W makes every segment number in range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_wr_i | input | 1 | Load the bank and length control register |
| ctl_bank_i | input | BANK_W | Bank to use for lookups |
| ctl_len_i | input | SEG_W+1 | Number of valid segments |
| tw_en_i | input | 1 | Descriptor write strobe |
| tw_bank_i | input | BANK_W | Bank of the descriptor written |
| tw_seg_i | input | SEG_W | Segment number of the descriptor written |
| tw_base_i | input | PA_W | Physical start address to store |
| tw_lim_i | input | OFF_W | Segment length to store |
| rq_valid_i | input | 1 | Translation request |
| rq_seg_i | input | SEG_W | Requested segment number |
| rq_off_i | input | OFF_W | Requested offset |
| rs_valid_o | output | 1 | Translation succeeded |
| rs_paddr_o | output | PA_W | Physical address, zero unless valid |
| rs_trap_o | output | 2 | Trap cause: 00 none, 01 segment out of range, 10 offset beyond length |

## Verification
The assertions assume that reset is asserted from time zero until the first clock edges have passed. They also assume that the request, write and control inputs hold known values at every rising edge, and that `BANKS` is a power of two, so that every bank index names real storage. The bench follows these assumptions. It holds reset low at start-up and changes inputs only one time unit after a rising edge. It reads back only descriptors it has written before, and it uses bank indices 0 and 1 only.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    TRAP_NONE = 2'b00,
    TRAP_SEG  = 2'b01,
    TRAP_LIM  = 2'b10
  } trap_e;
endpackage

// File: rtl/seg_ctl_regs.sv
module seg_ctl_regs #(
  parameter int SEG_W = 4,
  parameter int BANKS = 2,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [SEG_W:0]    len_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [SEG_W:0]    len_o
);
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [SEG_W:0]    len_q, len_d;

  always_comb begin
    bank_d = bank_q;
    len_d  = len_q;
    if (wr_i) begin
      bank_d = bank_i;
      len_d  = len_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
      len_q  <= '0;
    end else begin
      bank_q <= bank_d;
      len_q  <= len_d;
    end
  end

  assign bank_o = bank_q;
  assign len_o  = len_q;

  AST_CTL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(len_q) && $stable(bank_q))); // R9
endmodule

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_W = 4,
  parameter int OFF_W = 16,
  parameter int PA_W  = 24,
  parameter int BANKS = 2,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int IDX_W  = BANK_W + SEG_W,
  localparam int DEPTH  = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [BANK_W-1:0] wr_bank_i,
  input  logic [SEG_W-1:0]  wr_seg_i,
  input  logic [PA_W-1:0]   wr_base_i,
  input  logic [OFF_W-1:0]  wr_lim_i,
  input  logic [BANK_W-1:0] rd_bank_i,
  input  logic [SEG_W-1:0]  rd_seg_i,
  output logic [PA_W-1:0]   rd_base_o,
  output logic [OFF_W-1:0]  rd_lim_o
);
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  logic [PA_W-1:0]  base_arr [DEPTH];
  logic [OFF_W-1:0] lim_arr  [DEPTH];

  assign wr_idx = {wr_bank_i, wr_seg_i};
  assign rd_idx = {rd_bank_i, rd_seg_i};

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic             hit;
    logic [PA_W-1:0]  base_q;
    logic [OFF_W-1:0] lim_q;

    assign hit = wr_en_i && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk_i) begin
      if (hit) begin
        base_q <= wr_base_i;
        lim_q  <= wr_lim_i;
      end
    end

    assign base_arr[i] = base_q;
    assign lim_arr[i]  = lim_q;
  end

  assign rd_base_o = base_arr[rd_idx];
  assign rd_lim_o  = lim_arr[rd_idx];

  AST_WR_LANDS: assert property (@(posedge clk_i)
    (wr_en_i && (wr_idx == rd_idx)) |=>
      ((rd_idx != $past(rd_idx)) || (rd_base_o == $past(wr_base_i)))); // R7
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int OFF_W = 16,
  parameter int PA_W  = 24
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [SEG_W:0]   len_i,
  input  logic [PA_W-1:0]  base_i,
  input  logic [OFF_W-1:0] lim_i,
  output trap_e            trap_o,
  output logic [PA_W-1:0]  paddr_o
);
  logic seg_bad;
  logic off_bad;

  assign seg_bad = ({1'b0, seg_i} >= len_i);
  assign off_bad = (off_i >= lim_i);

  always_comb begin
    if (seg_bad)      trap_o = TRAP_SEG;
    else if (off_bad) trap_o = TRAP_LIM;
    else              trap_o = TRAP_NONE;
  end

  assign paddr_o = base_i + {{(PA_W-OFF_W){1'b0}}, off_i};
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int OFF_W = 16,
  parameter int PA_W  = 24,
  parameter int BANKS = 2,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_wr_i,
  input  logic [BANK_W-1:0] ctl_bank_i,
  input  logic [SEG_W:0]    ctl_len_i,
  input  logic              tw_en_i,
  input  logic [BANK_W-1:0] tw_bank_i,
  input  logic [SEG_W-1:0]  tw_seg_i,
  input  logic [PA_W-1:0]   tw_base_i,
  input  logic [OFF_W-1:0]  tw_lim_i,
  input  logic              rq_valid_i,
  input  logic [SEG_W-1:0]  rq_seg_i,
  input  logic [OFF_W-1:0]  rq_off_i,
  output logic              rs_valid_o,
  output logic [PA_W-1:0]   rs_paddr_o,
  output logic [1:0]        rs_trap_o
);
  logic [BANK_W-1:0] bank_sel;
  logic [SEG_W:0]    len_cur;
  logic [PA_W-1:0]   ent_base;
  logic [OFF_W-1:0]  ent_lim;
  trap_e             chk_trap;
  logic [PA_W-1:0]   chk_paddr;

  logic              valid_q, valid_d;
  logic [PA_W-1:0]   paddr_q, paddr_d;
  trap_e             trap_q, trap_d;

  seg_ctl_regs #(.SEG_W(SEG_W), .BANKS(BANKS)) u_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (ctl_wr_i),
    .bank_i (ctl_bank_i),
    .len_i  (ctl_len_i),
    .bank_o (bank_sel),
    .len_o  (len_cur)
  );

  seg_table #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .BANKS(BANKS)) u_tab (
    .clk_i     (clk_i),
    .wr_en_i   (tw_en_i),
    .wr_bank_i (tw_bank_i),
    .wr_seg_i  (tw_seg_i),
    .wr_base_i (tw_base_i),
    .wr_lim_i  (tw_lim_i),
    .rd_bank_i (bank_sel),
    .rd_seg_i  (rq_seg_i),
    .rd_base_o (ent_base),
    .rd_lim_o  (ent_lim)
  );

  seg_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
    .seg_i   (rq_seg_i),
    .off_i   (rq_off_i),
    .len_i   (len_cur),
    .base_i  (ent_base),
    .lim_i   (ent_lim),
    .trap_o  (chk_trap),
    .paddr_o (chk_paddr)
  );

  always_comb begin
    valid_d = 1'b0;
    paddr_d = '0;
    trap_d  = TRAP_NONE;
    if (rq_valid_i) begin
      trap_d = chk_trap;
      if (chk_trap == TRAP_NONE) begin
        valid_d = 1'b1;
        paddr_d = chk_paddr;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      paddr_q <= '0;
      trap_q  <= TRAP_NONE;
    end else begin
      valid_q <= valid_d;
      paddr_q <= paddr_d;
      trap_q  <= trap_d;
    end
  end

  assign rs_valid_o = valid_q;
  assign rs_paddr_o = paddr_q;
  assign rs_trap_o  = trap_q;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rq_valid_i |=> (!rs_valid_o && (rs_trap_o == 2'b00))); // R2
  AST_SEG_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rq_valid_i && ({1'b0, rq_seg_i} >= len_cur)) |=> (rs_trap_o == 2'b01)); // R3
  AST_LIM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rq_valid_i && ({1'b0, rq_seg_i} < len_cur) && (rq_off_i >= ent_lim))
      |=> (rs_trap_o == 2'b10)); // R4
  AST_TRAP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_valid_o |-> (rs_trap_o == 2'b00)); // R5
  AST_PADDR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rs_valid_o |-> (rs_paddr_o == '0)); // R3
  AST_NO_BOTH_CAUSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_trap_o != 2'b11); // R6
endmodule

// File: tb/test_seg_xlate_top.sv
module test_seg_xlate_top;
  logic        clk;
  logic        rst_n;
  logic        ctl_wr;
  logic [0:0]  ctl_bank;
  logic [4:0]  ctl_len;
  logic        tw_en;
  logic [0:0]  tw_bank;
  logic [3:0]  tw_seg;
  logic [23:0] tw_base;
  logic [15:0] tw_lim;
  logic        rq_valid;
  logic [3:0]  rq_seg;
  logic [15:0] rq_off;
  logic        rs_valid;
  logic [23:0] rs_paddr;
  logic [1:0]  rs_trap;

  int checks   = 0;
  int failures = 0;

  logic [23:0] m_base [2][16];
  logic [15:0] m_lim  [2][16];
  logic [0:0]  m_bank;
  logic [4:0]  m_len;

  seg_xlate_top i_seg_xlate_top (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ctl_wr_i   (ctl_wr),
    .ctl_bank_i (ctl_bank),
    .ctl_len_i  (ctl_len),
    .tw_en_i    (tw_en),
    .tw_bank_i  (tw_bank),
    .tw_seg_i   (tw_seg),
    .tw_base_i  (tw_base),
    .tw_lim_i   (tw_lim),
    .rq_valid_i (rq_valid),
    .rq_seg_i   (rq_seg),
    .rq_off_i   (rq_off),
    .rs_valid_o (rs_valid),
    .rs_paddr_o (rs_paddr),
    .rs_trap_o  (rs_trap)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R2 watchdog expired: actual=running expected=done");
    finish_run();
  end

  task automatic check_out(string req, logic ev, logic [23:0] ep, logic [1:0] et);
    checks++;
    if (rs_valid !== ev || rs_paddr !== ep || rs_trap !== et) begin
      failures++;
      $display("FAIL %s actual v=%0b pa=%h trap=%b expected v=%0b pa=%h trap=%b",
               req, rs_valid, rs_paddr, rs_trap, ev, ep, et);
    end
  endtask

  // Expected result from the model state at the request cycle
  task automatic expect_of(input logic [3:0] s, input logic [15:0] o,
                           output logic ev, output logic [23:0] ep, output logic [1:0] et);
    ev = 1'b0; ep = '0; et = 2'b00;
    if ({1'b0, s} >= m_len) et = 2'b01;
    else if (o >= m_lim[m_bank][s]) et = 2'b10;
    else begin
      ev = 1'b1;
      ep = m_base[m_bank][s] + {8'h00, o};
    end
  endtask

  task automatic table_wr(logic [0:0] b, logic [3:0] s, logic [23:0] base, logic [15:0] lim);
    tw_en = 1'b1; tw_bank = b; tw_seg = s; tw_base = base; tw_lim = lim;
    @(posedge clk); #1;
    tw_en = 1'b0;
    m_base[b][s] = base;
    m_lim[b][s]  = lim;
  endtask

  task automatic ctl_set(logic [0:0] b, logic [4:0] len);
    ctl_wr = 1'b1; ctl_bank = b; ctl_len = len;
    @(posedge clk); #1;
    ctl_wr = 1'b0;
    m_bank = b;
    m_len  = len;
  endtask

  task automatic request(string req, logic [3:0] s, logic [15:0] o);
    logic ev; logic [23:0] ep; logic [1:0] et;
    expect_of(s, o, ev, ep, et);
    rq_valid = 1'b1; rq_seg = s; rq_off = o;
    @(posedge clk); #1;
    rq_valid = 1'b0;
    check_out(req, ev, ep, et);
  endtask

  task automatic t_reset();
    check_out("R1 reset outputs", 1'b0, 24'h0, 2'b00);
    request("R1 length zero after reset", 4'd0, 16'd0);
    check_out("R1 explicit trap 01", 1'b0, 24'h0, 2'b01);
  endtask

  task automatic t_idle();
    @(posedge clk); #1;
    check_out("R2 idle cycle", 1'b0, 24'h0, 2'b00);
  endtask

  task automatic t_basic();
    table_wr(1'b0, 4'd0, 24'h010000, 16'h1000);
    table_wr(1'b0, 4'd3, 24'h123456, 16'h0100);
    table_wr(1'b0, 4'd7, 24'h000200, 16'hFFFF);
    ctl_set(1'b0, 5'd8);
    request("R5 seg0 off0", 4'd0, 16'h0000);
    check_out("R5 seg0 explicit", 1'b1, 24'h010000, 2'b00);
    request("R5 seg3 mid", 4'd3, 16'h0042);
    request("R5 seg7 large", 4'd7, 16'hABCD);
    // one-cycle latency: next cycle idle returns to quiet
    @(posedge clk); #1;
    check_out("R2 result lasts one cycle", 1'b0, 24'h0, 2'b00);
  endtask

  task automatic t_seg_range();
    request("R3 seg equal to length", 4'd8, 16'h0000);
    check_out("R3 explicit", 1'b0, 24'h0, 2'b01);
    request("R3 seg above length", 4'd15, 16'h0001);
  endtask

  task automatic t_limit();
    request("R4 off equals limit", 4'd3, 16'h0100);
    check_out("R4 explicit 10", 1'b0, 24'h0, 2'b10);
    request("R4 off limit-1 passes", 4'd3, 16'h00FF);
    check_out("R4 explicit pass", 1'b1, 24'h123555, 2'b00);
    table_wr(1'b0, 4'd5, 24'h000800, 16'h0000);
    request("R4 zero length traps", 4'd5, 16'h0000);
  endtask

  task automatic t_precedence();
    request("R6 both bad reports 01", 4'd9, 16'hFFFF);
    check_out("R6 explicit", 1'b0, 24'h0, 2'b01);
  endtask

  task automatic t_same_cycle();
    logic ev; logic [23:0] ep; logic [1:0] et;
    expect_of(4'd3, 16'h0010, ev, ep, et);
    tw_en = 1'b1; tw_bank = 1'b0; tw_seg = 4'd3; tw_base = 24'h700000; tw_lim = 16'h0020;
    rq_valid = 1'b1; rq_seg = 4'd3; rq_off = 16'h0010;
    @(posedge clk); #1;
    tw_en = 1'b0; rq_valid = 1'b0;
    check_out("R7 same-cycle lookup sees old entry", ev, ep, et);
    m_base[0][3] = 24'h700000;
    m_lim[0][3]  = 16'h0020;
    request("R7 next cycle sees new entry", 4'd3, 16'h0010);
    check_out("R7 explicit new", 1'b1, 24'h700010, 2'b00);
  endtask

  task automatic t_banks();
    table_wr(1'b1, 4'd3, 24'hA00000, 16'h8000);
    request("R8 other-bank write ignored", 4'd3, 16'h0010);
    check_out("R8 bank0 unchanged", 1'b1, 24'h700010, 2'b00);
    ctl_set(1'b1, 5'd8);
    request("R8 bank1 selected", 4'd3, 16'h0010);
    check_out("R8 bank1 explicit", 1'b1, 24'hA00010, 2'b00);
  endtask

  task automatic t_ctl_timing();
    logic ev; logic [23:0] ep; logic [1:0] et;
    expect_of(4'd3, 16'h0010, ev, ep, et);
    ctl_wr = 1'b1; ctl_bank = 1'b0; ctl_len = 5'd2;
    rq_valid = 1'b1; rq_seg = 4'd3; rq_off = 16'h0010;
    @(posedge clk); #1;
    ctl_wr = 1'b0; rq_valid = 1'b0;
    check_out("R9 write cycle uses old control", ev, ep, et);
    m_bank = 1'b0; m_len = 5'd2;
    request("R9 next cycle uses new length", 4'd3, 16'h0010);
    check_out("R9 explicit trap", 1'b0, 24'h0, 2'b01);
  endtask

  task automatic t_full_len();
    table_wr(1'b0, 4'd15, 24'hFFFFF0, 16'h0100);
    ctl_set(1'b0, 5'd16);
    request("R10 top segment in range", 4'd15, 16'h0004);
    // wraps modulo 2^24
    request("R5 address wraps", 4'd15, 16'h0020);
    check_out("R5 wrap explicit", 1'b1, 24'h000010, 2'b00);
  endtask

  initial begin
    rst_n = 1'b0;
    ctl_wr = 1'b0; ctl_bank = '0; ctl_len = '0;
    tw_en = 1'b0; tw_bank = '0; tw_seg = '0; tw_base = '0; tw_lim = '0;
    rq_valid = 1'b0; rq_seg = '0; rq_off = '0;
    m_bank = '0; m_len = '0;
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 16; s++) begin
        m_base[b][s] = '0;
        m_lim[b][s]  = '0;
      end
    repeat (3) @(posedge clk);
    #1;
    check_out("R1 outputs in reset", 1'b0, 24'h0, 2'b00);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_idle();
    t_basic();
    t_seg_range();
    t_limit();
    t_precedence();
    t_same_cycle();
    t_banks();
    t_ctl_timing();
    t_full_len();
    finish_run();
  end
endmodule